// File: doc/BRIEF.md
# Two-Master Bus Arbiter with Stateful Access Guard

This block sits between two processor masters and one shared memory/peripheral bus. In each cycle it accepts at most one request. A request is an address plus a read/write flag, and the master it comes from acts as its identity. The block compares the address with a fixed set of address windows. A small hard-wired policy automaton then decides whether that master may make that kind of access in the current policy state. An allowed request goes out on the bus port. A refused request is dropped and the master gets an error strobe instead.

Some writes act as control events. They hand ownership of the shared crypto window to one master, or give it back. Access to that window is therefore granted and withdrawn at run time. An event that is illegal in the current state puts the guard into a locked state. In that state every request is refused until reset.

Top module: `bus_ref_monitor`

## Requirements
- R1: After reset the policy state output is 0 (BASE), and no grant, error or bus_valid is asserted.
- R2: Handshake. A master holds its request and address until its ready output is high in the same cycle. Ready goes to at most one master per cycle. A lone requester is accepted at once. When both masters request, the one not served most recently wins, and M1 wins the first such tie after reset.
- R3: Exactly one cycle after acceptance, the accepted master sees exactly one of grant or error.
- R4: Access that needs no owner. Both masters may read and write 0x41400000–0x4140FFFF. M1 may read and write 0x40600000–0x4060FFFF and 0x24000000–0x24777777. M2 may read and write 0x40C00000–0x40C0FFFF and 0x24800000–0x24FFFFFF. All bounds are inclusive.
- R5: Owner-only access. The crypto window 0x28000000–0x28000777, which contains the control word 0x28000000–0x28000003, is open only to the current owner. M1 owns it in state 1 and M2 owns it in state 2. The window 0x28000800–0x28000FFF is refused to everyone.
- R6: Ownership events. From BASE, a write by M1 to 0x28000004–0x28000007 moves the state to 1 (M1_OWN), and the same write by M2 moves it to 2 (M2_OWN). Either write is granted. A write by the owner to 0x28000008–0x2800000F is granted and returns the state to 0.
- R7: Reads of either event window are not events. They are judged as ordinary crypto-window accesses and never change the state.
- R8: A write to an event window that is not a legal event in the current state is refused and moves the state to 3 (LOCKED). In LOCKED every request is refused and only reset leaves it.
- R9: Apart from R8, a refused request never reaches the bus (bus_valid stays low) and leaves the policy state unchanged.
- R10: When bus_valid is high, bus_addr, bus_we and bus_master (0 = M1, 1 = M2) carry the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m1_req | input | 1 | M1 request pending |
| m1_addr | input | 32 | M1 address |
| m1_we | input | 1 | M1 write (1) or read (0) |
| m1_ready | output | 1 | M1 request accepted this cycle |
| m2_req | input | 1 | M2 request pending |
| m2_addr | input | 32 | M2 address |
| m2_we | input | 1 | M2 write (1) or read (0) |
| m2_ready | output | 1 | M2 request accepted this cycle |
| m1_grant | output | 1 | M1 access forwarded (one cycle after accept) |
| m1_err | output | 1 | M1 access refused (one cycle after accept) |
| m2_grant | output | 1 | M2 access forwarded |
| m2_err | output | 1 | M2 access refused |
| bus_valid | output | 1 | Forwarded access present on the bus |
| bus_addr | output | 32 | Forwarded address |
| bus_we | output | 1 | Forwarded write flag |
| bus_master | output | 1 | Forwarded master identity |
| policy_state | output | 2 | Policy state: 0 BASE, 1 M1_OWN, 2 M2_OWN, 3 LOCKED |

## Verification
The ready outputs are combinational. They are due in the cycle the request is presented, so the bench checks them shortly after driving its inputs on the falling edge. Grant, error, the bus fields and the new policy state all come from one register stage. They are due one cycle after acceptance, so at each falling edge the bench compares them with the prediction its model made one edge earlier. The model keeps its own state, its own last-served pointer and per-master request queues, so tie-breaking and lock-out are predicted without reference to the RTL.

// File: rtl/brm_pkg.sv
package brm_pkg;

    localparam int ADDR_W     = 32;
    localparam int NUM_RANGES = 10;
    localparam int NUM_MST    = 2;

    // window indices
    localparam int WIN_DEBUG  = 0;
    localparam int WIN_CRYPTO = 1;
    localparam int WIN_SPARE  = 2;
    localparam int WIN_MEM_A  = 3;
    localparam int WIN_MEM_B  = 4;
    localparam int WIN_UART   = 5;
    localparam int WIN_NET    = 6;
    localparam int WIN_TAKE   = 7;
    localparam int WIN_GIVE   = 8;
    localparam int WIN_CTRL   = 9;

    typedef enum logic [1:0] {
        ST_BASE   = 2'd0,
        ST_M1_OWN = 2'd1,
        ST_M2_OWN = 2'd2,
        ST_LOCKED = 2'd3
    } pol_state_e;

    function automatic logic [ADDR_W-1:0] win_lo(input int idx);
        case (idx)
            WIN_DEBUG:  win_lo = 32'h4140_0000;
            WIN_CRYPTO: win_lo = 32'h2800_0000;
            WIN_SPARE:  win_lo = 32'h2800_0800;
            WIN_MEM_A:  win_lo = 32'h2400_0000;
            WIN_MEM_B:  win_lo = 32'h2480_0000;
            WIN_UART:   win_lo = 32'h4060_0000;
            WIN_NET:    win_lo = 32'h40C0_0000;
            WIN_TAKE:   win_lo = 32'h2800_0004;
            WIN_GIVE:   win_lo = 32'h2800_0008;
            default:    win_lo = 32'h2800_0000;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] win_hi(input int idx);
        case (idx)
            WIN_DEBUG:  win_hi = 32'h4140_FFFF;
            WIN_CRYPTO: win_hi = 32'h2800_0777;
            WIN_SPARE:  win_hi = 32'h2800_0FFF;
            WIN_MEM_A:  win_hi = 32'h2477_7777;
            WIN_MEM_B:  win_hi = 32'h24FF_FFFF;
            WIN_UART:   win_hi = 32'h4060_FFFF;
            WIN_NET:    win_hi = 32'h40C0_FFFF;
            WIN_TAKE:   win_hi = 32'h2800_0007;
            WIN_GIVE:   win_hi = 32'h2800_000F;
            default:    win_hi = 32'h2800_0003;
        endcase
    endfunction

endpackage

// File: rtl/brm_range_decode.sv
module brm_range_decode
    import brm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_RANGES
) (
    input  logic [AW-1:0] addr,
    output logic [NR-1:0] hit
);

    for (genvar g = 0; g < NR; g++) begin : g_win
        localparam logic [AW-1:0] LO = AW'(win_lo(g));
        localparam logic [AW-1:0] HI = AW'(win_hi(g));
        assign hit[g] = (addr >= LO) && (addr <= HI);
    end

endmodule

// File: rtl/brm_arbiter.sv
module brm_arbiter
    import brm_pkg::*;
#(
    parameter int NM = NUM_MST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req,
    input  logic          last_q,
    output logic [NM-1:0] ready,
    output logic          sel
);

    always_comb begin
        if (req[0] && req[1]) begin
            sel = ~last_q;
        end else begin
            sel = req[1];
        end
        ready      = '0;
        ready[sel] = req[sel];
    end

    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ready)); // R2
    AST_TIE_TO_M2: assert property (@(posedge clk) disable iff (!rst_n)
        (req[0] && req[1] && !last_q) |-> ready[1]); // R2
    AST_LONE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (req[0] && !req[1]) |-> ready[0]); // R2

endmodule

// File: rtl/brm_policy.sv
module brm_policy
    import brm_pkg::*;
#(
    parameter int NR = NUM_RANGES
) (
    input  pol_state_e    state,
    input  logic          who,
    input  logic          we,
    input  logic [NR-1:0] hit,
    output logic          allow,
    output pol_state_e    state_nxt
);

    logic event_wr;
    logic is_owner;
    logic open_hit;

    assign event_wr = we && (hit[WIN_TAKE] || hit[WIN_GIVE]);
    assign is_owner = (state == ST_M1_OWN && !who) || (state == ST_M2_OWN && who);
    assign open_hit = hit[WIN_DEBUG]
                    || (!who && (hit[WIN_UART] || hit[WIN_MEM_A]))
                    || ( who && (hit[WIN_NET]  || hit[WIN_MEM_B]));

    always_comb begin
        allow     = 1'b0;
        state_nxt = state;
        if (state == ST_LOCKED) begin
            allow = 1'b0;
        end else if (event_wr) begin
            if (state == ST_BASE && hit[WIN_TAKE]) begin
                allow     = 1'b1;
                state_nxt = who ? ST_M2_OWN : ST_M1_OWN;
            end else if (is_owner && hit[WIN_GIVE]) begin
                allow     = 1'b1;
                state_nxt = ST_BASE;
            end else begin
                state_nxt = ST_LOCKED;
            end
        end else begin
            allow = open_hit
                 || (is_owner && (hit[WIN_CTRL] || hit[WIN_CRYPTO]));
        end
    end

endmodule

// File: rtl/bus_ref_monitor.sv
module bus_ref_monitor
    import brm_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m1_req,
    input  logic [AW-1:0] m1_addr,
    input  logic          m1_we,
    output logic          m1_ready,
    input  logic          m2_req,
    input  logic [AW-1:0] m2_addr,
    input  logic          m2_we,
    output logic          m2_ready,
    output logic          m1_grant,
    output logic          m1_err,
    output logic          m2_grant,
    output logic          m2_err,
    output logic          bus_valid,
    output logic [AW-1:0] bus_addr,
    output logic          bus_we,
    output logic          bus_master,
    output logic [1:0]    policy_state
);

    typedef struct packed {
        pol_state_e          state;
        logic                last;
        logic                bvalid;
        logic [AW-1:0]       baddr;
        logic                bwe;
        logic                bmst;
        logic [NUM_MST-1:0]  grant;
        logic [NUM_MST-1:0]  err;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_MST-1:0]    ready;
    logic                  sel;
    logic [AW-1:0]         sel_addr;
    logic                  sel_we;
    logic [NUM_RANGES-1:0] hit;
    logic                  allow;
    pol_state_e            state_nxt;

    brm_arbiter #(.NM(NUM_MST)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    ({m2_req, m1_req}),
        .last_q (r_q.last),
        .ready  (ready),
        .sel    (sel)
    );

    assign sel_addr = sel ? m2_addr : m1_addr;
    assign sel_we   = sel ? m2_we   : m1_we;

    brm_range_decode #(.AW(AW), .NR(NUM_RANGES)) u_dec (
        .addr (sel_addr),
        .hit  (hit)
    );

    brm_policy #(.NR(NUM_RANGES)) u_pol (
        .state     (r_q.state),
        .who       (sel),
        .we        (sel_we),
        .hit       (hit),
        .allow     (allow),
        .state_nxt (state_nxt)
    );

    always_comb begin
        r_d        = r_q;
        r_d.bvalid = 1'b0;
        r_d.grant  = '0;
        r_d.err    = '0;
        if (|ready) begin
            r_d.last  = sel;
            r_d.state = state_nxt;
            if (allow) begin
                r_d.bvalid     = 1'b1;
                r_d.baddr      = sel_addr;
                r_d.bwe        = sel_we;
                r_d.bmst       = sel;
                r_d.grant[sel] = 1'b1;
            end else begin
                r_d.err[sel]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_BASE;
            r_q.last   <= 1'b1;
        end else begin
            r_q        <= r_d;
        end
    end

    assign m1_ready     = ready[0];
    assign m2_ready     = ready[1];
    assign m1_grant     = r_q.grant[0];
    assign m2_grant     = r_q.grant[1];
    assign m1_err       = r_q.err[0];
    assign m2_err       = r_q.err[1];
    assign bus_valid    = r_q.bvalid;
    assign bus_addr     = r_q.baddr;
    assign bus_we       = r_q.bwe;
    assign bus_master   = r_q.bmst;
    assign policy_state = r_q.state;

    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_ready || m2_ready) |=> ((m1_grant || m1_err) != (m2_grant || m2_err))); // R3
    AST_NO_IDLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(m1_ready || m2_ready) |=> !(m1_grant || m1_err || m2_grant || m2_err)); // R3
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_state == 2'd3) |=> (policy_state == 2'd3)); // R8
    AST_LOCKED_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_state == 2'd3 && (m1_ready || m2_ready)) |=> !bus_valid); // R8
    AST_REFUSE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((m1_err || m2_err) && policy_state != 2'd3) |-> $stable(policy_state)); // R9
    AST_FWD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_master ? m2_grant : m1_grant)); // R10

endmodule

// File: tb/bus_ref_monitor_tb.sv
module bus_ref_monitor_tb;

    typedef struct {
        logic [31:0] a;
        bit          w;
        string       tag;
    } req_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m1_req = 1'b0, m2_req = 1'b0;
    logic [31:0] m1_addr = '0, m2_addr = '0;
    logic        m1_we = 1'b0, m2_we = 1'b0;
    logic        m1_ready, m2_ready, m1_grant, m1_err, m2_grant, m2_err;
    logic        bus_valid, bus_we, bus_master;
    logic [31:0] bus_addr;
    logic [1:0]  policy_state;

    always #5 clk = ~clk;

    bus_ref_monitor u_dut (
        .clk(clk), .rst_n(rst_n),
        .m1_req(m1_req), .m1_addr(m1_addr), .m1_we(m1_we), .m1_ready(m1_ready),
        .m2_req(m2_req), .m2_addr(m2_addr), .m2_we(m2_we), .m2_ready(m2_ready),
        .m1_grant(m1_grant), .m1_err(m1_err), .m2_grant(m2_grant), .m2_err(m2_err),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_master(bus_master), .policy_state(policy_state)
    );

    int checks = 0;
    int errors = 0;

    req_t q1[$];
    req_t q2[$];

    // model state
    int          m_state = 0;
    int          m_last  = 1;
    // expected registered outputs
    bit          e_g1, e_e1, e_g2, e_e2, e_bv, e_bwe, e_bm;
    logic [31:0] e_ba;
    string       e_tag = "R1";

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit inr(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    task automatic judge(input int st, input int m, input bit w, input logic [31:0] a,
                         output bit ok, output int ns);
        bit t_take, t_give;
        t_take = inr(a, 32'h2800_0004, 32'h2800_0007);
        t_give = inr(a, 32'h2800_0008, 32'h2800_000F);
        ns = st;
        ok = 0;
        if (st == 3) begin
            ok = 0;
        end else if (w && (t_take || t_give)) begin
            if (st == 0 && t_take) begin
                ok = 1; ns = m + 1;
            end else if (st == m + 1 && t_give) begin
                ok = 1; ns = 0;
            end else begin
                ok = 0; ns = 3;
            end
        end else begin
            ok = inr(a, 32'h4140_0000, 32'h4140_FFFF)
              || (m == 0 && (inr(a, 32'h4060_0000, 32'h4060_FFFF) || inr(a, 32'h2400_0000, 32'h2477_7777)))
              || (m == 1 && (inr(a, 32'h40C0_0000, 32'h40C0_FFFF) || inr(a, 32'h2480_0000, 32'h24FF_FFFF)))
              || (st == m + 1 && inr(a, 32'h2800_0000, 32'h2800_0777));
        end
    endtask

    task automatic check_outputs();
        chk(e_tag, "m1_grant", m1_grant, e_g1);
        chk(e_tag, "m1_err",   m1_err,   e_e1);
        chk(e_tag, "m2_grant", m2_grant, e_g2);
        chk(e_tag, "m2_err",   m2_err,   e_e2);
        chk("R9",  "bus_valid", bus_valid, e_bv);
        chk("R6",  "policy_state", policy_state, m_state);
        if (e_bv) begin
            chk("R10", "bus_addr",   bus_addr,   e_ba);
            chk("R10", "bus_we",     bus_we,     e_bwe);
            chk("R10", "bus_master", bus_master, e_bm);
        end
    endtask

    task automatic step();
        bit   r1, r2, ok;
        int   sel, ns;
        req_t cur;
        @(negedge clk);
        check_outputs();
        r1 = (q1.size() > 0);
        r2 = (q2.size() > 0);
        m1_req = r1; m2_req = r2;
        if (r1) begin m1_addr = q1[0].a; m1_we = q1[0].w; end
        if (r2) begin m2_addr = q2[0].a; m2_we = q2[0].w; end
        #1;
        sel = -1;
        if (r1 && r2)  sel = (m_last == 1) ? 0 : 1;
        else if (r1)   sel = 0;
        else if (r2)   sel = 1;
        chk("R2", "m1_ready", m1_ready, sel == 0);
        chk("R2", "m2_ready", m2_ready, sel == 1);
        {e_g1, e_e1, e_g2, e_e2, e_bv} = '0;
        if (sel >= 0) begin
            cur = (sel == 0) ? q1.pop_front() : q2.pop_front();
            judge(m_state, sel, cur.w, cur.a, ok, ns);
            e_tag = cur.tag;
            m_last = sel;
            m_state = ns;
            e_bv = ok;
            e_ba = cur.a; e_bwe = cur.w; e_bm = (sel == 1);
            if (sel == 0) begin e_g1 = ok; e_e1 = !ok; end
            else          begin e_g2 = ok; e_e2 = !ok; end
        end else begin
            e_tag = "R3";
        end
    endtask

    task automatic drain();
        while (q1.size() > 0 || q2.size() > 0) step();
        step();
        step();
        m1_req = 1'b0; m2_req = 1'b0;
    endtask

    task automatic push(input int m, input logic [31:0] a, input bit w, input string tag);
        req_t r;
        r.a = a; r.w = w; r.tag = tag;
        if (m == 0) q1.push_back(r); else q2.push_back(r);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; m1_req = 1'b0; m2_req = 1'b0;
        q1.delete(); q2.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_state = 0; m_last = 1;
        {e_g1, e_e1, e_g2, e_e2, e_bv} = '0;
        e_tag = "R1";
        #1;
        chk("R1", "state after reset", policy_state, 0);
        chk("R1", "bus_valid after reset", bus_valid, 0);
        chk("R1", "results after reset", {m1_grant, m1_err, m2_grant, m2_err}, 0);
    endtask

    initial begin
        do_reset();
        // R4 open windows and boundaries
        push(0, 32'h4060_0010, 0, "R4");
        push(0, 32'h2477_7777, 1, "R4");
        push(0, 32'h2477_7778, 0, "R4");
        push(0, 32'h40C0_0000, 0, "R4");
        push(1, 32'h40C0_FFFF, 1, "R4");
        push(1, 32'h2480_0000, 0, "R4");
        push(1, 32'h4140_0000, 1, "R4");
        push(1, 32'h2400_0000, 0, "R4");
        drain();
        // R5 / R7 / R9 in BASE: crypto refused, event read not an event
        push(0, 32'h2800_0000, 1, "R5");
        push(0, 32'h2800_0004, 0, "R7");
        push(1, 32'h2800_0900, 0, "R9");
        drain();
        // R6 M1 takes ownership
        push(0, 32'h2800_0004, 1, "R6");
        drain();
        // R2 tie, R5 owner vs non-owner
        push(0, 32'h2800_0000, 1, "R5");
        push(1, 32'h2800_0100, 0, "R5");
        push(0, 32'h2800_0777, 0, "R5");
        push(0, 32'h2800_0778, 0, "R5");
        push(0, 32'h2800_0008, 0, "R7");
        push(1, 32'h2800_0800, 1, "R5");
        drain();
        // R6 give back, then M2 takes
        push(0, 32'h2800_000C, 1, "R6");
        drain();
        push(1, 32'h2800_0007, 1, "R6");
        drain();
        push(1, 32'h2800_0777, 0, "R5");
        push(0, 32'h2800_0010, 0, "R5");
        drain();
        // R8 non-owner giving back -> locked
        push(0, 32'h2800_0008, 1, "R8");
        drain();
        push(0, 32'h4060_0000, 0, "R8");
        push(1, 32'h2800_0000, 0, "R8");
        push(1, 32'h2800_0008, 1, "R8");
        drain();
        do_reset();
        push(1, 32'h2800_0004, 1, "R6");
        push(0, 32'h2800_0004, 1, "R8");
        drain();
        do_reset();
        push(0, 32'h4140_FFFF, 1, "R1");
        drain();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule